// File: doc/BRIEF.md
# Crash-Recovery Commit Evaluator

After a crash, a recovery pass walks the persistent log one speculation window at a time. This block decides which transactions of a single window are committed. Nothing is taken from a commit record. The block counts the tagged data blocks that survived for each transaction and compares that count with the block total that the transaction stored in one of its tags. It then corrects the counts with dependency pairs. A dependency pair records how many writes of a transaction were coalesced into a later transaction. Finally it applies in-order commit across the window.

The recovery engine feeds one record per cycle: transaction declarations in program order, then the block tags, then the dependency pairs in log order, then an end marker. The block then works on its own. It folds in the basic count comparison and then the pairs, starting from the newest. It streams one verdict per declared transaction in program order and raises a done pulse. After that it is ready for the next window, and no state from the previous window carries over.

Top module: `rce_commit_eval`

## Requirements
- R1: After reset, out_valid and done are low and the block accepts records.
- R2: in_kind encodes 0 = declare transaction (slots numbered from 0 in arrival order, which is program order), 1 = block tag, 2 = dependency pair, 3 = end of window. A tag counts toward the declared transaction whose core, thread and transaction ID all match. A transaction whose tag count equals the non-zero in_num of one of its tags is committed.
- R3: A transaction whose tag count differs from its stored non-zero total is discarded.
- R4: A transaction with no tag that carries a non-zero in_num is discarded.
- R5: For a dependency pair, in_core/in_thread/in_txid name the older transaction, in_peer_* name its successor, and in_num is the number of coalesced writes. If the successor is committed, in_num is added to the older transaction's count before the comparison.
- R6: If the successor of a dependency pair is not committed, the older transaction is discarded.
- R7: Dependency pairs are applied newest first, so a chain of pairs resolves from the tail of the log toward its head.
- R8: Once a transaction is discarded, every later transaction of the window is discarded.
- R9: Verdicts appear one per cycle with out_slot counting up from 0, each with the transaction identity. done is a single-cycle pulse in the cycle after the last verdict. A window with no declarations gives done and no verdicts.
- R10: Each window starts from clean counts. A transaction identity reused in a later window is judged only on that window's records.
- R11: The block ignores declarations beyond MAX_TXN, pairs beyond MAX_DEP, tags or pairs that name an undeclared identity, and records that arrive while it is not accepting.
- R12: Per-transaction counts saturate at 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Record present this cycle |
| in_kind | input | 2 | Record kind (see R2) |
| in_core | input | CORE_W | Core ID of the transaction named by the record |
| in_thread | input | THREAD_W | Thread ID of that transaction |
| in_txid | input | TXID_W | Transaction ID of that transaction |
| in_peer_core | input | CORE_W | Successor core ID (dependency pairs) |
| in_peer_thread | input | THREAD_W | Successor thread ID |
| in_peer_txid | input | TXID_W | Successor transaction ID |
| in_num | input | CNT_W | Stored block total (tags) or coalesced-write count (pairs) |
| out_valid | output | 1 | Verdict present |
| out_slot | output | clog2(MAX_TXN) | Program-order position of the verdict |
| out_core | output | CORE_W | Core ID of the judged transaction |
| out_thread | output | THREAD_W | Thread ID of the judged transaction |
| out_txid | output | TXID_W | Transaction ID of the judged transaction |
| out_commit | output | 1 | 1 = committed, 0 = discarded |
| done | output | 1 | Window finished |

## Verification
The bench builds the block with MAX_TXN=4, MAX_DEP=2 and CNT_W=3. With these values a fifth declaration overflows the slot table. Nine tags against a stored total of 7 probe count saturation, because a wrapping counter would read 1. Two chained pairs exactly fill the pair store, and their outcome depends on the order in which the pairs are applied. Back-to-back windows reuse identities so that stale counts would show up as wrong verdicts.

// File: rtl/rce_pkg.sv
package rce_pkg;

    parameter int CORE_W   = 2;
    parameter int THREAD_W = 2;
    parameter int TXID_W   = 6;

    typedef struct packed {
        logic [CORE_W-1:0]   core;
        logic [THREAD_W-1:0] thread;
        logic [TXID_W-1:0]   txid;
    } txn_id_t;

    typedef enum logic [1:0] {
        REC_TXN = 2'd0,
        REC_TAG = 2'd1,
        REC_DEP = 2'd2,
        REC_END = 2'd3
    } rec_kind_t;

    typedef enum logic [2:0] {
        PH_LOAD,
        PH_BASE,
        PH_DEP,
        PH_OUT,
        PH_FIN
    } phase_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rce_slot_table.sv
module rce_slot_table
    import rce_pkg::*;
#(
    parameter int MAX_TXN = 16,
    parameter int CNT_W   = 4,
    localparam int SLOT_W = idx_width(MAX_TXN),
    localparam int NS_W   = $clog2(MAX_TXN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              alloc_en,
    input  txn_id_t           alloc_id,
    input  txn_id_t           lk_a_id,
    output logic              lk_a_hit,
    output logic [SLOT_W-1:0] lk_a_idx,
    input  txn_id_t           lk_b_id,
    output logic              lk_b_hit,
    output logic [SLOT_W-1:0] lk_b_idx,
    input  logic              tag_en,
    input  logic [CNT_W-1:0]  tag_num,
    input  logic              base_en,
    input  logic              adj_en,
    input  logic [SLOT_W-1:0] adj_tx,
    input  logic [SLOT_W-1:0] adj_ty,
    input  logic [CNT_W-1:0]  adj_n,
    input  logic [SLOT_W-1:0] rd_idx,
    output txn_id_t           rd_id,
    output logic [NS_W-1:0]   n_slots,
    output logic [MAX_TXN-1:0] ok_vec
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [MAX_TXN-1:0] match_a;
    logic [MAX_TXN-1:0] match_b;
    txn_id_t            id_arr [MAX_TXN];
    logic               room;

    assign room = (n_slots < NS_W'(MAX_TXN));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            n_slots <= '0;
        end else if (alloc_en && room) begin
            n_slots <= n_slots + 1'b1;
        end
    end

    for (genvar i = 0; i < MAX_TXN; i++) begin : g_slot
        localparam logic [NS_W-1:0]   IDX_N = NS_W'(i);
        localparam logic [SLOT_W-1:0] IDX_S = SLOT_W'(i);

        txn_id_t          id_q;
        logic [CNT_W-1:0] cnt_q;
        logic [CNT_W-1:0] total_q;
        logic             seen_q;
        logic             ok_q;
        logic             live;
        logic [CNT_W:0]   sum_raw;
        logic [CNT_W-1:0] sum_sat;

        assign live    = (IDX_N < n_slots);
        assign sum_raw = {1'b0, cnt_q} + {1'b0, adj_n};
        assign sum_sat = sum_raw[CNT_W] ? CNT_MAX : sum_raw[CNT_W-1:0];

        always_ff @(posedge clk) begin
            if (rst) begin
                id_q    <= '0;
                cnt_q   <= '0;
                total_q <= '0;
                seen_q  <= 1'b0;
                ok_q    <= 1'b0;
            end else if (alloc_en && room && (n_slots == IDX_N)) begin
                id_q    <= alloc_id;
                cnt_q   <= '0;
                total_q <= '0;
                seen_q  <= 1'b0;
                ok_q    <= 1'b0;
            end else if (tag_en && lk_a_hit && (lk_a_idx == IDX_S)) begin
                if (cnt_q != CNT_MAX) begin
                    cnt_q <= cnt_q + 1'b1;
                end
                if (tag_num != '0) begin
                    total_q <= tag_num;
                    seen_q  <= 1'b1;
                end
            end else if (base_en) begin
                ok_q <= live && seen_q && (cnt_q == total_q);
            end else if (adj_en && (adj_tx == IDX_S)) begin
                if (ok_vec[adj_ty]) begin
                    cnt_q <= sum_sat;
                    ok_q  <= seen_q && (sum_sat == total_q);
                end else begin
                    ok_q  <= 1'b0;
                end
            end
        end

        assign match_a[i] = live && (id_q == lk_a_id);
        assign match_b[i] = live && (id_q == lk_b_id);
        assign ok_vec[i]  = ok_q;
        assign id_arr[i]  = id_q;
    end

    always_comb begin
        lk_a_hit = 1'b0;
        lk_a_idx = '0;
        lk_b_hit = 1'b0;
        lk_b_idx = '0;
        for (int i = MAX_TXN - 1; i >= 0; i--) begin
            if (match_a[i]) begin
                lk_a_hit = 1'b1;
                lk_a_idx = SLOT_W'(i);
            end
            if (match_b[i]) begin
                lk_b_hit = 1'b1;
                lk_b_idx = SLOT_W'(i);
            end
        end
    end

    assign rd_id = id_arr[rd_idx];

endmodule

// File: rtl/rce_dep_store.sv
module rce_dep_store
    import rce_pkg::*;
#(
    parameter int MAX_DEP = 8,
    parameter int SLOT_W  = 4,
    parameter int CNT_W   = 4,
    localparam int DP_W   = idx_width(MAX_DEP),
    localparam int DN_W   = $clog2(MAX_DEP + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_tx,
    input  logic [SLOT_W-1:0] wr_ty,
    input  logic [CNT_W-1:0]  wr_n,
    input  logic [DP_W-1:0]   rd_idx,
    output logic [SLOT_W-1:0] rd_tx,
    output logic [SLOT_W-1:0] rd_ty,
    output logic [CNT_W-1:0]  rd_n,
    output logic [DN_W-1:0]   n_deps
);

    logic [SLOT_W-1:0] tx_mem [MAX_DEP];
    logic [SLOT_W-1:0] ty_mem [MAX_DEP];
    logic [CNT_W-1:0]  n_mem  [MAX_DEP];
    logic [DP_W-1:0]   wr_ptr;

    assign wr_ptr = DP_W'(n_deps);

    always_ff @(posedge clk) begin
        if (rst) begin
            n_deps <= '0;
            for (int i = 0; i < MAX_DEP; i++) begin
                tx_mem[i] <= '0;
                ty_mem[i] <= '0;
                n_mem[i]  <= '0;
            end
        end else if (clr) begin
            n_deps <= '0;
        end else if (wr_en && (n_deps < DN_W'(MAX_DEP))) begin
            tx_mem[wr_ptr] <= wr_tx;
            ty_mem[wr_ptr] <= wr_ty;
            n_mem[wr_ptr]  <= wr_n;
            n_deps         <= n_deps + 1'b1;
        end
    end

    assign rd_tx = tx_mem[rd_idx];
    assign rd_ty = ty_mem[rd_idx];
    assign rd_n  = n_mem[rd_idx];

endmodule

// File: rtl/rce_order_gate.sv
module rce_order_gate #(
    parameter int MAX_TXN = 16
) (
    input  logic [MAX_TXN-1:0] ok_vec,
    output logic [MAX_TXN-1:0] keep_vec
);

    assign keep_vec[0] = ok_vec[0];

    for (genvar i = 1; i < MAX_TXN; i++) begin : g_chain
        assign keep_vec[i] = keep_vec[i-1] & ok_vec[i];
    end

endmodule

// File: rtl/rce_commit_eval.sv
module rce_commit_eval
    import rce_pkg::*;
#(
    parameter int MAX_TXN = 16,
    parameter int MAX_DEP = 8,
    parameter int CNT_W   = 4,
    localparam int SLOT_W = idx_width(MAX_TXN),
    localparam int NS_W   = $clog2(MAX_TXN + 1),
    localparam int DP_W   = idx_width(MAX_DEP),
    localparam int DN_W   = $clog2(MAX_DEP + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [1:0]          in_kind,
    input  logic [CORE_W-1:0]   in_core,
    input  logic [THREAD_W-1:0] in_thread,
    input  logic [TXID_W-1:0]   in_txid,
    input  logic [CORE_W-1:0]   in_peer_core,
    input  logic [THREAD_W-1:0] in_peer_thread,
    input  logic [TXID_W-1:0]   in_peer_txid,
    input  logic [CNT_W-1:0]    in_num,
    output logic                out_valid,
    output logic [SLOT_W-1:0]   out_slot,
    output logic [CORE_W-1:0]   out_core,
    output logic [THREAD_W-1:0] out_thread,
    output logic [TXID_W-1:0]   out_txid,
    output logic                out_commit,
    output logic                done
);

    phase_t            ph;
    rec_kind_t         kind;
    txn_id_t           rec_id;
    txn_id_t           peer_id;
    txn_id_t           rd_id;
    logic              loading;
    logic              alloc_en;
    logic              tag_en;
    logic              dep_wr;
    logic              clr;
    logic              a_hit, b_hit;
    logic [SLOT_W-1:0] a_idx, b_idx;
    logic [SLOT_W-1:0] out_ptr;
    logic [DP_W-1:0]   dep_ptr;
    logic [SLOT_W-1:0] dep_tx, dep_ty;
    logic [CNT_W-1:0]  dep_n;
    logic [NS_W-1:0]   n_slots;
    logic [DN_W-1:0]   n_deps;
    logic [MAX_TXN-1:0] ok_vec;
    logic [MAX_TXN-1:0] keep_vec;
    logic              last_slot;

    assign kind    = rec_kind_t'(in_kind);
    assign rec_id  = '{core: in_core, thread: in_thread, txid: in_txid};
    assign peer_id = '{core: in_peer_core, thread: in_peer_thread, txid: in_peer_txid};

    assign loading  = (ph == PH_LOAD) && in_valid;
    assign alloc_en = loading && (kind == REC_TXN);
    assign tag_en   = loading && (kind == REC_TAG);
    assign dep_wr   = loading && (kind == REC_DEP) && a_hit && b_hit;
    assign clr      = (ph == PH_FIN) || ((ph == PH_OUT) && (n_slots == '0));
    assign last_slot = (NS_W'(out_ptr) == (n_slots - 1'b1));

    rce_slot_table #(
        .MAX_TXN (MAX_TXN),
        .CNT_W   (CNT_W)
    ) u_slots (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .alloc_en (alloc_en),
        .alloc_id (rec_id),
        .lk_a_id  (rec_id),
        .lk_a_hit (a_hit),
        .lk_a_idx (a_idx),
        .lk_b_id  (peer_id),
        .lk_b_hit (b_hit),
        .lk_b_idx (b_idx),
        .tag_en   (tag_en),
        .tag_num  (in_num),
        .base_en  (ph == PH_BASE),
        .adj_en   (ph == PH_DEP),
        .adj_tx   (dep_tx),
        .adj_ty   (dep_ty),
        .adj_n    (dep_n),
        .rd_idx   (out_ptr),
        .rd_id    (rd_id),
        .n_slots  (n_slots),
        .ok_vec   (ok_vec)
    );

    rce_dep_store #(
        .MAX_DEP (MAX_DEP),
        .SLOT_W  (SLOT_W),
        .CNT_W   (CNT_W)
    ) u_deps (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .wr_en  (dep_wr),
        .wr_tx  (a_idx),
        .wr_ty  (b_idx),
        .wr_n   (in_num),
        .rd_idx (dep_ptr),
        .rd_tx  (dep_tx),
        .rd_ty  (dep_ty),
        .rd_n   (dep_n),
        .n_deps (n_deps)
    );

    rce_order_gate #(
        .MAX_TXN (MAX_TXN)
    ) u_order (
        .ok_vec   (ok_vec),
        .keep_vec (keep_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph         <= PH_LOAD;
            out_ptr    <= '0;
            dep_ptr    <= '0;
            out_valid  <= 1'b0;
            out_slot   <= '0;
            out_core   <= '0;
            out_thread <= '0;
            out_txid   <= '0;
            out_commit <= 1'b0;
            done       <= 1'b0;
        end else begin
            done      <= 1'b0;
            out_valid <= 1'b0;
            case (ph)
                PH_LOAD: begin
                    if (in_valid && (kind == REC_END)) begin
                        ph <= PH_BASE;
                    end
                end
                PH_BASE: begin
                    out_ptr <= '0;
                    if (n_deps != '0) begin
                        dep_ptr <= DP_W'(n_deps - 1'b1);
                        ph      <= PH_DEP;
                    end else begin
                        ph <= PH_OUT;
                    end
                end
                PH_DEP: begin
                    if (dep_ptr == '0) begin
                        ph <= PH_OUT;
                    end else begin
                        dep_ptr <= dep_ptr - 1'b1;
                    end
                end
                PH_OUT: begin
                    if (n_slots == '0) begin
                        done <= 1'b1;
                        ph   <= PH_LOAD;
                    end else begin
                        out_valid  <= 1'b1;
                        out_slot   <= out_ptr;
                        out_core   <= rd_id.core;
                        out_thread <= rd_id.thread;
                        out_txid   <= rd_id.txid;
                        out_commit <= keep_vec[out_ptr];
                        if (last_slot) begin
                            ph <= PH_FIN;
                        end else begin
                            out_ptr <= out_ptr + 1'b1;
                        end
                    end
                end
                PH_FIN: begin
                    done <= 1'b1;
                    ph   <= PH_LOAD;
                end
                default: ph <= PH_LOAD;
            endcase
        end
    end

endmodule

// File: rtl/rce_commit_eval_chk.sv
module rce_commit_eval_chk #(
    parameter int SLOT_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              out_valid,
    input logic [SLOT_W-1:0] out_slot,
    input logic              out_commit,
    input logic              done
);

    // R1: first cycle out of reset is quiet
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !done));

    // R9: verdict stream starts at slot 0
    a_r9_first_slot: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (out_slot == '0));

    // R9: consecutive verdicts step the slot by one
    a_r9_slot_step: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> (out_slot == SLOT_W'($past(out_slot) + 1'b1)));

    // R9: done never overlaps a verdict and lasts one cycle
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid);

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: no commit after a discard within one stream
    a_r8_no_commit_after_discard: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid) && !$past(out_commit)) |-> !out_commit);

endmodule

bind rce_commit_eval rce_commit_eval_chk #(.SLOT_W(SLOT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .out_valid  (out_valid),
    .out_slot   (out_slot),
    .out_commit (out_commit),
    .done       (done)
);

// File: tb/rce_commit_eval_bench.sv
module rce_commit_eval_bench;
    import rce_pkg::*;

    localparam int MT = 4;
    localparam int MD = 2;
    localparam int CW = 3;
    localparam int SW = 2;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic [1:0]          in_kind = '0;
    logic [CORE_W-1:0]   in_core = '0;
    logic [THREAD_W-1:0] in_thread = '0;
    logic [TXID_W-1:0]   in_txid = '0;
    logic [CORE_W-1:0]   in_peer_core = '0;
    logic [THREAD_W-1:0] in_peer_thread = '0;
    logic [TXID_W-1:0]   in_peer_txid = '0;
    logic [CW-1:0]       in_num = '0;
    logic                out_valid;
    logic [SW-1:0]       out_slot;
    logic [CORE_W-1:0]   out_core;
    logic [THREAD_W-1:0] out_thread;
    logic [TXID_W-1:0]   out_txid;
    logic                out_commit;
    logic                done;

    always #5 clk = ~clk;

    rce_commit_eval #(.MAX_TXN(MT), .MAX_DEP(MD), .CNT_W(CW)) u_rce_commit_eval (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
        .in_core(in_core), .in_thread(in_thread), .in_txid(in_txid),
        .in_peer_core(in_peer_core), .in_peer_thread(in_peer_thread),
        .in_peer_txid(in_peer_txid), .in_num(in_num),
        .out_valid(out_valid), .out_slot(out_slot), .out_core(out_core),
        .out_thread(out_thread), .out_txid(out_txid), .out_commit(out_commit),
        .done(done)
    );

    typedef struct {
        int    slot;
        int    core;
        int    thread;
        int    txid;
        bit    commit;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    bit   done_flag = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic expect_v(input int slot, input int c, input int t, input int x,
                            input bit commit, input string req);
        exp_t e;
        e.slot = slot; e.core = c; e.thread = t; e.txid = x;
        e.commit = commit; e.req = req;
        exp_q.push_back(e);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9", "unexpected verdict slot", int'(out_slot), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(int'(out_slot) == e.slot, "R9", "slot order", int'(out_slot), e.slot);
                chk(int'(out_core) == e.core && int'(out_thread) == e.thread &&
                    int'(out_txid) == e.txid, "R9", "identity txid",
                    int'(out_txid), e.txid);
                chk(out_commit == e.commit, e.req, "verdict", int'(out_commit),
                    int'(e.commit));
            end
        end
        if (!rst && done) done_flag = 1'b1;
    end

    task automatic send(input rec_kind_t k, input int c, input int t, input int x,
                        input int pc, input int pt, input int px, input int n);
        in_valid       = 1'b1;
        in_kind        = 2'(k);
        in_core        = CORE_W'(c);
        in_thread      = THREAD_W'(t);
        in_txid        = TXID_W'(x);
        in_peer_core   = CORE_W'(pc);
        in_peer_thread = THREAD_W'(pt);
        in_peer_txid   = TXID_W'(px);
        in_num         = CW'(n);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic decl(input int c, input int t, input int x);
        send(REC_TXN, c, t, x, 0, 0, 0, 0);
    endtask

    task automatic tag(input int c, input int t, input int x, input int n);
        send(REC_TAG, c, t, x, 0, 0, 0, n);
    endtask

    task automatic dep(input int c, input int t, input int x,
                       input int pc, input int pt, input int px, input int n);
        send(REC_DEP, c, t, x, pc, pt, px, n);
    endtask

    task automatic close_window();
        send(REC_END, 0, 0, 0, 0, 0, 0, 0);
        while (!done_flag) @(negedge clk);
        done_flag = 1'b0;
        chk(exp_q.size() == 0, "R9", "verdicts missing at done", exp_q.size(), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0 && done == 1'b0, "R1", "idle after reset",
            int'(out_valid) + int'(done), 0);

        // Window 1: R2 match on full triple, R3 mismatch, R11 undeclared tag
        expect_v(0, 0, 0, 1, 1'b1, "R2");
        expect_v(1, 0, 0, 2, 1'b1, "R2");
        expect_v(2, 1, 0, 1, 1'b0, "R3");
        decl(0, 0, 1);
        decl(0, 0, 2);
        decl(1, 0, 1);
        tag(0, 0, 1, 0);
        tag(0, 0, 2, 0);
        tag(3, 3, 9, 1);
        tag(0, 0, 1, 2);
        tag(1, 0, 1, 2);
        tag(0, 0, 2, 0);
        tag(0, 0, 2, 3);
        close_window();

        // Window 2: R10 reuse of identity, R4 no total, R8 truncation, R11 capacity
        expect_v(0, 0, 0, 1, 1'b1, "R10");
        expect_v(1, 0, 0, 2, 1'b0, "R4");
        expect_v(2, 2, 1, 5, 1'b0, "R8");
        expect_v(3, 2, 1, 6, 1'b0, "R8");
        decl(0, 0, 1);
        decl(0, 0, 2);
        decl(2, 1, 5);
        decl(2, 1, 6);
        decl(3, 0, 7);
        tag(0, 0, 1, 1);
        tag(0, 0, 2, 0);
        tag(0, 0, 2, 0);
        tag(2, 1, 5, 1);
        tag(2, 1, 6, 1);
        tag(3, 0, 7, 1);
        close_window();

        // Window 3: R5 successor committed adds n, R7 chain resolved tail first
        expect_v(0, 1, 1, 10, 1'b1, "R7");
        expect_v(1, 1, 1, 11, 1'b1, "R5");
        expect_v(2, 1, 1, 12, 1'b1, "R5");
        decl(1, 1, 10);
        decl(1, 1, 11);
        decl(1, 1, 12);
        tag(1, 1, 10, 3);
        tag(1, 1, 11, 2);
        tag(1, 1, 12, 0);
        tag(1, 1, 12, 2);
        dep(1, 1, 10, 1, 1, 11, 2);
        dep(1, 1, 11, 1, 1, 12, 1);
        close_window();

        // Window 4: R6 successor discarded forces discard
        expect_v(0, 2, 2, 20, 1'b0, "R6");
        expect_v(1, 2, 2, 21, 1'b0, "R3");
        decl(2, 2, 20);
        decl(2, 2, 21);
        tag(2, 2, 20, 2);
        tag(2, 2, 21, 3);
        dep(2, 2, 20, 2, 2, 21, 1);
        close_window();

        // Window 5: R12 saturating count (9 tags, stored total 7)
        expect_v(0, 3, 3, 30, 1'b1, "R12");
        decl(3, 3, 30);
        for (int i = 0; i < 8; i++) tag(3, 3, 30, 0);
        tag(3, 3, 30, 7);
        close_window();

        // Window 6: R9 empty window gives done without verdicts
        close_window();
        chk(out_valid == 1'b0, "R9", "no verdict in empty window", int'(out_valid), 0);

        // Window 7: R11 records after end of window are ignored
        expect_v(0, 0, 1, 40, 1'b1, "R11");
        decl(0, 1, 40);
        tag(0, 1, 40, 1);
        send(REC_END, 0, 0, 0, 0, 0, 0, 0);
        tag(0, 1, 40, 0);
        while (!done_flag) @(negedge clk);
        done_flag = 1'b0;
        chk(exp_q.size() == 0, "R11", "verdicts missing at done", exp_q.size(), 0);

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule